// File: doc/BRIEF.md
# Toggle-Bit Completion Poller

This block sits on the host side of a parallel flash interface. After a program or erase command has been written, it works out whether the device has finished. It does this by reading the device status byte again and again and looking at two bits. Bit 6 flips on every read while the internal algorithm runs. Bit 5 rises when the device has run past its internal time limit. The block issues its reads as single-cycle requests on a simple request/valid bus. It accepts one response per request, and it reports the outcome as a one-cycle pass or fail pulse.

When the outcome is a failure, the block drives one write cycle carrying the reset command byte. This returns the device to reading array data, and the fail pulse follows that write. The host can pause the poller at any moment with a yield input. On resuming, the poller starts over with a fresh pair of reads instead of trusting a comparison that was only half done. A parameter caps the total number of reads per operation, so a device that never settles still ends the operation with a failure.

Top module: `tglpoll`

## Requirements
- R1: A start pulse while idle raises busy in the next cycle, and a read request (bus_req high, bus_we low) follows in that same cycle. Only one read is outstanding at a time, and no new request is issued until the response to the previous one has arrived on bus_rvalid.
- R2: Status bit 6 is the toggle bit. If the two reads of a pair return the same bit 6, the block pulses done_ok and issues no write.
- R3: Status bit 5 is the time-limit flag. If bit 6 differs between the two reads of a pair and the second read has bit 5 low, the block starts a new pair of reads and reports nothing.
- R4: If bit 6 differs and the second read has bit 5 high, the block makes exactly two more reads. If those two agree on bit 6, it pulses done_ok.
- R5: If the two re-check reads still differ on bit 6, the block issues one write cycle (bus_req and bus_we high, bus_wdata 0xF0), and done_fail pulses in the cycle after that write.
- R6: While yield_req is high, no read request is issued. A response that arrives while yielded is discarded. Once yield_req is low and no read is outstanding, polling resumes with the first read of a new pair.
- R7: Once MAX_READS reads have been issued in one operation without a verdict, no further read is made. The block performs the 0xF0 write and then pulses done_fail.
- R8: done_ok and done_fail each last one cycle and are never high together. busy stays high from the cycle after start through the report cycle and is low in the cycle after it.
- R9: A start pulse while busy is ignored. The running operation continues unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin polling (single-cycle pulse) |
| yield_req | input | 1 | Host asks the poller to stand off the bus |
| bus_req | output | 1 | Bus cycle request, one cycle per access |
| bus_we | output | 1 | Qualifies bus_req as a write |
| bus_wdata | output | 8 | Write data (reset command) |
| bus_rvalid | input | 1 | Read response strobe |
| bus_rdata | input | 8 | Status byte returned by a read |
| busy | output | 1 | Operation in progress |
| done_ok | output | 1 | Operation finished successfully (pulse) |
| done_fail | output | 1 | Operation failed (pulse) |

## Verification
Two situations are hard to reach from the ports. The first is a yield that lands while a read response is still in flight. The bench uses a read latency of several cycles and raises yield_req two cycles after the request. The stale response therefore arrives during the pause, and the bench checks that it is dropped and that the poller waits for it before issuing anything new. The second is the late-stopping toggle during the bit 5 re-check. Scripted status sequences lead the poller into the re-check path and end it one way or the other. A per-cycle behavioural model compares every output against the design on each clock.

// File: rtl/tglpoll_pkg.sv
`timescale 1ns/1ps
package tglpoll_pkg;

    localparam int          STAT_W    = 8;
    localparam int          TOG_POS   = 6;
    localparam int          ERR_POS   = 5;
    localparam logic [7:0]  RESET_CMD = 8'hF0;

    typedef enum logic [2:0] {
        S_IDLE,
        S_ISSUE,
        S_WAIT,
        S_PAUSE,
        S_RSTWR,
        S_PASS,
        S_FAIL
    } ctl_state_e;

    // Position of the current read within a comparison
    typedef enum logic [1:0] {
        P_PAIR1,
        P_PAIR2,
        P_RECHK1,
        P_RECHK2
    } read_slot_e;

    typedef struct packed {
        logic       pass;
        logic       fail;
        logic       keep;
        read_slot_e next_slot;
    } slot_outcome_t;

    // Judge one returned status byte against the stored toggle value
    function automatic slot_outcome_t judge(read_slot_e slot, logic ref_bit,
                                            logic [STAT_W-1:0] stat);
        slot_outcome_t o;
        logic          same;
        o           = '0;
        o.next_slot = P_PAIR1;
        same        = (stat[TOG_POS] == ref_bit);
        unique case (slot)
            P_PAIR1: begin
                o.keep      = 1'b1;
                o.next_slot = P_PAIR2;
            end
            P_PAIR2: begin
                if (same)              o.pass      = 1'b1;
                else if (stat[ERR_POS]) o.next_slot = P_RECHK1;
                else                   o.next_slot = P_PAIR1;
            end
            P_RECHK1: begin
                o.keep      = 1'b1;
                o.next_slot = P_RECHK2;
            end
            P_RECHK2: begin
                if (same) o.pass = 1'b1;
                else      o.fail = 1'b1;
            end
            default: o.next_slot = P_PAIR1;
        endcase
        return o;
    endfunction

endpackage

// File: rtl/tglpoll_budget.sv
`timescale 1ns/1ps
module tglpoll_budget #(
    parameter int MAX_READS = 1024
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic inc,
    output logic exhausted
);
    localparam int CNT_W = $clog2(MAX_READS + 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clr) cnt <= '0;
        else if (inc)   cnt <= cnt + 1'b1;
    end

    assign exhausted = (cnt == CNT_W'(MAX_READS));
endmodule

// File: rtl/tglpoll_track.sv
`timescale 1ns/1ps
module tglpoll_track (
    input  logic clk,
    input  logic rst,
    input  logic rd_fire,
    input  logic rvalid,
    output logic pending
);
    always_ff @(posedge clk) begin
        if (rst)          pending <= 1'b0;
        else if (rd_fire) pending <= 1'b1;
        else if (rvalid)  pending <= 1'b0;
    end
endmodule

// File: rtl/tglpoll_fsm.sv
`timescale 1ns/1ps
module tglpoll_fsm
    import tglpoll_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              yield_req,
    input  logic              rvalid,
    input  logic [STAT_W-1:0] rdata,
    input  logic              exhausted,
    input  logic              pending,
    output logic              rd_fire,
    output logic              cnt_clr,
    output logic              bus_req,
    output logic              bus_we,
    output logic [STAT_W-1:0] bus_wdata,
    output logic              busy,
    output logic              done_ok,
    output logic              done_fail
);
    ctl_state_e    st, st_nxt;
    read_slot_e    slot, slot_nxt;
    logic          ref_bit, ref_nxt;
    slot_outcome_t oc;

    always_comb begin
        st_nxt    = st;
        slot_nxt  = slot;
        ref_nxt   = ref_bit;
        rd_fire   = 1'b0;
        cnt_clr   = 1'b0;
        bus_req   = 1'b0;
        bus_we    = 1'b0;
        bus_wdata = '0;
        oc        = judge(slot, ref_bit, rdata);
        unique case (st)
            S_IDLE: if (start) begin
                st_nxt   = S_ISSUE;
                slot_nxt = P_PAIR1;
                cnt_clr  = 1'b1;
            end
            S_ISSUE: begin
                if (yield_req)      st_nxt = S_PAUSE;
                else if (exhausted) st_nxt = S_RSTWR;
                else begin
                    bus_req = 1'b1;
                    rd_fire = 1'b1;
                    st_nxt  = S_WAIT;
                end
            end
            S_WAIT: begin
                if (yield_req) st_nxt = S_PAUSE;
                else if (rvalid) begin
                    if (oc.keep) ref_nxt = rdata[TOG_POS];
                    if (oc.pass)      st_nxt = S_PASS;
                    else if (oc.fail) st_nxt = S_RSTWR;
                    else begin
                        st_nxt   = S_ISSUE;
                        slot_nxt = oc.next_slot;
                    end
                end
            end
            S_PAUSE: if (!yield_req && !pending) begin
                st_nxt   = S_ISSUE;
                slot_nxt = P_PAIR1;
            end
            S_RSTWR: begin
                bus_req   = 1'b1;
                bus_we    = 1'b1;
                bus_wdata = RESET_CMD;
                st_nxt    = S_FAIL;
            end
            S_PASS, S_FAIL: st_nxt = S_IDLE;
            default:        st_nxt = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= S_IDLE;
            slot    <= P_PAIR1;
            ref_bit <= 1'b0;
        end else begin
            st      <= st_nxt;
            slot    <= slot_nxt;
            ref_bit <= ref_nxt;
        end
    end

    assign busy      = (st != S_IDLE);
    assign done_ok   = (st == S_PASS);
    assign done_fail = (st == S_FAIL);
endmodule

// File: rtl/tglpoll.sv
`timescale 1ns/1ps
module tglpoll
    import tglpoll_pkg::*;
#(
    parameter int MAX_READS = 1024
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              yield_req,
    output logic              bus_req,
    output logic              bus_we,
    output logic [STAT_W-1:0] bus_wdata,
    input  logic              bus_rvalid,
    input  logic [STAT_W-1:0] bus_rdata,
    output logic              busy,
    output logic              done_ok,
    output logic              done_fail
);
    logic rd_fire;
    logic cnt_clr;
    logic exhausted;
    logic rd_pending;

    tglpoll_budget #(.MAX_READS(MAX_READS)) u_budget (
        .clk       (clk),
        .rst       (rst),
        .clr       (cnt_clr),
        .inc       (rd_fire),
        .exhausted (exhausted)
    );

    tglpoll_track u_track (
        .clk     (clk),
        .rst     (rst),
        .rd_fire (rd_fire),
        .rvalid  (bus_rvalid),
        .pending (rd_pending)
    );

    tglpoll_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .yield_req (yield_req),
        .rvalid    (bus_rvalid),
        .rdata     (bus_rdata),
        .exhausted (exhausted),
        .pending   (rd_pending),
        .rd_fire   (rd_fire),
        .cnt_clr   (cnt_clr),
        .bus_req   (bus_req),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .busy      (busy),
        .done_ok   (done_ok),
        .done_fail (done_fail)
    );
endmodule

// File: rtl/tglpoll_chk.sv
`timescale 1ns/1ps
module tglpoll_chk (
    input logic       clk,
    input logic       rst,
    input logic       start,
    input logic       yield_req,
    input logic       busy,
    input logic       bus_req,
    input logic       bus_we,
    input logic [7:0] bus_wdata,
    input logic       done_ok,
    input logic       done_fail,
    input logic       pend
);
    // R8
    pulse_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(done_ok && done_fail));
    // R8
    ok_single_chk: assert property (@(posedge clk) disable iff (rst)
        done_ok |=> !done_ok);
    // R8
    idle_after_report_chk: assert property (@(posedge clk) disable iff (rst)
        (done_ok || done_fail) |=> !busy);
    // R1
    one_outstanding_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_req && !bus_we) |-> !pend);
    // R1
    start_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);
    // R5
    rst_data_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_req && bus_we) |-> (bus_wdata == 8'hF0));
    // R5
    wr_then_fail_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_req && bus_we) |=> done_fail);
    // R6
    yield_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        yield_req |-> !(bus_req && !bus_we));
endmodule

bind tglpoll tglpoll_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .yield_req (yield_req),
    .busy      (busy),
    .bus_req   (bus_req),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .done_ok   (done_ok),
    .done_fail (done_fail),
    .pend      (rd_pending)
);

// File: tb/tglpoll_bench.sv
`timescale 1ns/1ps
module tglpoll_bench;
    localparam int MAXR = 8;

    logic       clk = 1'b0;
    logic       rst, start, yield_req;
    logic       bus_req, bus_we, bus_rvalid;
    logic [7:0] bus_wdata, bus_rdata;
    logic       busy, done_ok, done_fail;

    int checks = 0;
    int errors = 0;
    int n_ok   = 0;
    int n_fail = 0;
    int lat    = 1;
    int cd     = 0;
    logic [7:0] stat_q[$];
    logic [7:0] wr_log[$];

    always #4 clk = ~clk;

    tglpoll #(.MAX_READS(MAXR)) u_tglpoll (
        .clk(clk), .rst(rst), .start(start), .yield_req(yield_req),
        .bus_req(bus_req), .bus_we(bus_we), .bus_wdata(bus_wdata),
        .bus_rvalid(bus_rvalid), .bus_rdata(bus_rdata),
        .busy(busy), .done_ok(done_ok), .done_fail(done_fail)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // bus responder: one response lat cycles after each read request
    initial begin
        bus_rvalid = 1'b0;
        bus_rdata  = 8'h00;
        forever begin
            @(negedge clk);
            #1;
            if (cd == 1) begin
                bus_rvalid = 1'b1;
                bus_rdata  = (stat_q.size() > 0) ? stat_q.pop_front() : 8'h00;
                cd = 0;
            end else begin
                bus_rvalid = 1'b0;
                if (cd > 1) cd--;
            end
            if (bus_req && !bus_we) cd = lat;
            if (bus_req && bus_we)  wr_log.push_back(bus_wdata);
        end
    end

    // behavioural reference: 0 idle 1 issue 2 wait 3 pause 4 reset-write 5 pass 6 fail
    int m_mode = 0, m_idx = 0, m_reads = 0;
    bit m_ref = 0, m_pend = 0;
    always @(posedge clk) begin
        bit fire;
        int nm;
        fire = 0;
        nm   = m_mode;
        if (rst) begin
            m_mode = 0; m_pend = 0; m_reads = 0; m_idx = 0;
        end else begin
            case (m_mode)
                0: if (start) begin nm = 1; m_idx = 0; m_reads = 0; end
                1: if (yield_req) nm = 3;
                   else if (m_reads >= MAXR) nm = 4;
                   else begin fire = 1; m_reads++; nm = 2; end
                2: if (yield_req) nm = 3;
                   else if (bus_rvalid) begin
                       if (m_idx == 0 || m_idx == 2) begin
                           m_ref = bus_rdata[6]; m_idx++; nm = 1;
                       end else if (bus_rdata[6] == m_ref) nm = 5;
                       else if (m_idx == 3) nm = 4;
                       else if (bus_rdata[5]) begin m_idx = 2; nm = 1; end
                       else begin m_idx = 0; nm = 1; end
                   end
                3: if (!yield_req && !m_pend) begin nm = 1; m_idx = 0; end
                4: nm = 6;
                default: nm = 0;
            endcase
            if (fire) m_pend = 1;
            else if (bus_rvalid) m_pend = 0;
            m_mode = nm;
        end
    end

    // per-cycle comparison, away from the clock edge
    initial begin
        forever begin
            bit e_req;
            @(negedge clk);
            #2;
            if (!rst) begin
                e_req = (m_mode == 1 && !yield_req && m_reads < MAXR) || m_mode == 4;
                chk(bus_req == e_req, "R1 bus_req", bus_req, e_req);
                chk(bus_we == (m_mode == 4), "R5 bus_we", bus_we, m_mode == 4);
                if (m_mode == 4) chk(bus_wdata == 8'hF0, "R5 bus_wdata", bus_wdata, 8'hF0);
                chk(busy == (m_mode != 0), "R8 busy", busy, m_mode != 0);
                chk(done_ok == (m_mode == 5), "R2 done_ok", done_ok, m_mode == 5);
                chk(done_fail == (m_mode == 6), "R5 done_fail", done_fail, m_mode == 6);
                if (done_ok)   n_ok++;
                if (done_fail) n_fail++;
            end
        end
    end

    task automatic do_start();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    task automatic wait_result(input int base);
        int w = 0;
        while (n_ok + n_fail == base && w < 3000) begin
            @(negedge clk); #3; w++;
        end
        repeat (2) @(negedge clk);
        #3;
    endtask

    task automatic run_case(input string tag, input int latency, input bit exp_pass,
                            input int exp_wr);
        int ok0, f0, w0;
        ok0 = n_ok; f0 = n_fail; w0 = wr_log.size();
        lat = latency;
        do_start();
        wait_result(ok0 + f0);
        chk(n_ok - ok0 == int'(exp_pass), {tag, " pass count"}, n_ok - ok0, exp_pass);
        chk(n_fail - f0 == int'(!exp_pass), {tag, " fail count"}, n_fail - f0, !exp_pass);
        chk(wr_log.size() - w0 == exp_wr, {tag, " writes"}, wr_log.size() - w0, exp_wr);
        if (exp_wr > 0)
            chk(wr_log[wr_log.size()-1] == 8'hF0, {tag, " write data"},
                wr_log[wr_log.size()-1], 8'hF0);
        chk(stat_q.size() == 0, {tag, " reads consumed"}, stat_q.size(), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int ok0;
        rst = 1'b1; start = 1'b0; yield_req = 1'b0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk); #3;
        // R8 reset state
        chk(!busy && !bus_req && !done_ok && !done_fail, "R8 reset state", busy, 0);

        // R2 steady toggle bit: immediate success
        stat_q.push_back(8'h40); stat_q.push_back(8'h40);
        run_case("R2 steady", 1, 1'b1, 0);

        // R3 toggling with flag low, then settles on next pair
        stat_q = '{8'h00, 8'h40, 8'h00, 8'h00};
        run_case("R3 new pair", 3, 1'b1, 0);

        // R4 flag high, toggle stops during re-check
        stat_q = '{8'h00, 8'h60, 8'h20, 8'h20};
        run_case("R4 recheck settles", 2, 1'b1, 0);

        // R5 flag high, toggle persists: reset write then fail
        stat_q = '{8'h00, 8'h60, 8'h20, 8'h60};
        run_case("R5 recheck fails", 1, 1'b0, 1);

        // R7 never settles: budget of MAXR reads runs out
        for (int i = 0; i < MAXR; i++) stat_q.push_back((i % 2) ? 8'h40 : 8'h00);
        run_case("R7 budget", 1, 1'b0, 1);

        // R9 start while busy is ignored
        ok0 = n_ok + n_fail;
        stat_q = '{8'h00, 8'h40, 8'h40, 8'h40};
        lat = 3;
        do_start();
        repeat (4) @(negedge clk);
        start = 1'b1;
        @(negedge clk); start = 1'b0;
        wait_result(ok0);
        chk(n_ok + n_fail - ok0 == 1, "R9 single result", n_ok + n_fail - ok0, 1);
        chk(stat_q.size() == 0, "R9 reads consumed", stat_q.size(), 0);

        // R6 yield between reads, resume with a fresh pair
        ok0 = n_ok + n_fail;
        stat_q = '{8'h40};
        lat = 2;
        do_start();
        wait (stat_q.size() == 0);
        @(negedge clk); yield_req = 1'b1;
        stat_q = '{8'h00, 8'h00};
        repeat (5) @(negedge clk);
        #3;
        chk(busy && !bus_req, "R6 quiet while yielded", bus_req, 0);
        @(negedge clk); yield_req = 1'b0;
        wait_result(ok0);
        chk(n_ok + n_fail - ok0 == 1 && stat_q.size() == 0, "R6 fresh pair after yield",
            stat_q.size(), 0);

        // R6 yield with a response still in flight: stale data dropped
        ok0 = n_ok;
        stat_q = '{8'h44};
        lat = 4;
        do_start();
        repeat (2) @(negedge clk);
        yield_req = 1'b1;
        wait (stat_q.size() == 0);
        stat_q = '{8'h40, 8'h40};
        repeat (4) @(negedge clk);
        yield_req = 1'b0;
        wait_result(ok0 + n_fail);
        chk(n_ok - ok0 == 1, "R6 in-flight drop", n_ok - ok0, 1);
        chk(stat_q.size() == 0, "R6 in-flight reads", stat_q.size(), 0);

        // R1 back-to-back operations after a result
        stat_q = '{8'h00, 8'h00};
        run_case("R1 restart", 5, 1'b1, 0);

        repeat (3) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule